// File: doc/BRIEF.md
# Card Clock Divider with Committed Updates

This block produces the clock driven to an SD/MMC card from the host's source clock. The source clock is divided by an even ratio and can be gated off. The gate can also be set to stop the clock on its own whenever the command and data path has nothing to do. Software programs a half-ratio value and the gate settings into staging registers. Writing those registers changes nothing at the output.

The staged values reach the generator only when software issues an update command. That command is a write to the command register with a start bit and an update flag set. The start bit stays readable as 1 while the update is pending. The hardware then copies the staged values at a point where the switch cannot produce a short pulse, and clears the start bit by itself. An optional flag in the same command holds the update back for as long as the data path reports busy.

The intended software sequence is: turn the clock off, write the new half-ratio, update, turn the clock on, update again. The block itself places no order on these steps.

Top module: `card_clk_div`

## Requirements
- R1: After a synchronous reset the card clock is low, the start bit reads 0, and the staged half-ratio and gate settings read 0.
- R2: Writing the half-ratio register (address 0, bits 7:0) or the gate register (address 1) only changes the staged values read back from those addresses. The card clock keeps its current waveform until an update commits.
- R3: A write to the command register (address 2) with bit 31 and bit 21 both set starts an update, and bit 31 then reads 1 until the update commits. A write with bit 31 set but bit 21 clear is ignored, and bit 31 keeps reading 0.
- R4: With a committed half-ratio N from 1 to 255, the enabled card clock is high for N source cycles and low for N source cycles. N = 255 gives a ratio of 510.
- R5: With a committed half-ratio of 0 and the clock enabled, the card clock follows the source clock: high in its high phase, low in its low phase.
- R6: Bit 0 of the gate register enables the card clock. With a committed value of 0 the card clock stays low.
- R7: Bit 16 of the gate register selects low-power gating. When it is committed and path_idle is high, the card clock is held low. When path_idle drops, the clock runs again at the committed ratio.
- R8: When the update command also has bit 13 set, the commit is held off for as long as data_busy is high. Without bit 13 the update commits while data_busy is high.
- R9: In divided mode a commit takes effect only at the source edge where the card clock falls. It restarts the count, so the first new half-period is a full low phase. No high pulse is ever cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 half-ratio, 1 gate, 2 command |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| data_busy | input | 1 | Data path busy, honoured by updates that carry bit 13 |
| path_idle | input | 1 | Command and data path idle, used by low-power gating |
| cclk_o | output | 1 | Card clock |

## Verification
The assertions assume the following about the inputs:
- reg_addr, reg_wdata and reg_wr are stable around each rising source edge.
- path_idle is stable at both source edges, because the passthrough gate samples it on the falling edge.
- Reset is applied for at least one full source cycle.

The stimulus meets these conditions by changing every input half a nanosecond after a rising edge, well before the following falling edge. The reference model uses the input values from that same update. The stimulus never writes a new update command while one is pending; a completion poll waits for the start bit to clear first. Because of this, the case where a pending command is ignored never occurs in the stimulus.

// File: rtl/cclk_pkg.sv
`timescale 1ns/100ps
package cclk_pkg;

    // Width of the half-ratio field.
    parameter int unsigned CCLK_DIV_W = 8;

    // Register selects.
    localparam int unsigned SEL_DIV = 0;
    localparam int unsigned SEL_GATE = 1;
    localparam int unsigned SEL_CMD = 2;

    // Field positions decoded by software.
    localparam int unsigned GATE_ON_BIT = 0;
    localparam int unsigned GATE_LP_BIT = 16;
    localparam int unsigned CMD_START_BIT = 31;
    localparam int unsigned CMD_UPD_BIT = 21;
    localparam int unsigned CMD_WAIT_BIT = 13;

    typedef struct packed {
        logic [CCLK_DIV_W-1:0] ratio;  // half of the division ratio, 0 = pass
        logic run;                     // clock enabled
        logic sleep;                   // stop while path idle
    } cclk_cfg_t;

    // Gate decision for a configuration given the current idle state.
    function automatic logic gate_want(cclk_cfg_t c, logic idle);
        return c.run && !(c.sleep && idle);
    endfunction

endpackage

// File: rtl/cclk_stage.sv
`timescale 1ns/100ps
module cclk_stage
    import cclk_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              safe,
    output cclk_cfg_t         stg,
    output logic              pend,
    output logic              hold_busy,
    output logic              commit,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned W = CCLK_DIV_W;

    cclk_cfg_t stg_q;
    logic      pend_q;
    logic      wait_q;

    logic hit_div;
    logic hit_gate;
    logic hit_cmd;
    logic upd_req;

    assign hit_div  = wr && (addr == ADDR_W'(SEL_DIV));
    assign hit_gate = wr && (addr == ADDR_W'(SEL_GATE));
    assign hit_cmd  = wr && (addr == ADDR_W'(SEL_CMD));
    assign upd_req  = hit_cmd && wdata[CMD_START_BIT] && wdata[CMD_UPD_BIT];

    assign commit = pend_q && !(wait_q && busy) && safe;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q  <= '0;
            pend_q <= 1'b0;
            wait_q <= 1'b0;
        end else begin
            if (hit_div) begin
                stg_q.ratio <= wdata[W-1:0];
            end
            if (hit_gate) begin
                stg_q.run   <= wdata[GATE_ON_BIT];
                stg_q.sleep <= wdata[GATE_LP_BIT];
            end
            if (commit) begin
                pend_q <= 1'b0;
                wait_q <= 1'b0;
            end else if (upd_req && !pend_q) begin
                pend_q <= 1'b1;
                wait_q <= wdata[CMD_WAIT_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(SEL_DIV)) begin
            rdata[W-1:0] = stg_q.ratio;
        end else if (addr == ADDR_W'(SEL_GATE)) begin
            rdata[GATE_ON_BIT] = stg_q.run;
            rdata[GATE_LP_BIT] = stg_q.sleep;
        end else if (addr == ADDR_W'(SEL_CMD)) begin
            rdata[CMD_START_BIT] = pend_q;
            rdata[CMD_UPD_BIT]   = pend_q;
            rdata[CMD_WAIT_BIT]  = wait_q;
        end
    end

    assign stg       = stg_q;
    assign pend      = pend_q;
    assign hold_busy = wait_q;

endmodule

// File: rtl/cclk_core.sv
`timescale 1ns/100ps
module cclk_core
    import cclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      commit,
    input  cclk_cfg_t stg,
    input  logic      idle,
    output cclk_cfg_t act,
    output logic      tog,
    output logic      gate,
    output logic      safe,
    output logic      pass_mode,
    output logic      want_now
);

    localparam int unsigned W = CCLK_DIV_W;

    cclk_cfg_t     act_q;
    logic [W-1:0]  cnt_q;
    logic          tog_q;
    logic          gate_q;

    logic div_mode;
    logic term;
    logic fall;

    assign div_mode = (act_q.ratio != '0);
    assign term     = div_mode && (cnt_q == act_q.ratio - W'(1));
    assign fall     = term && tog_q;
    assign safe     = !div_mode || fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            cnt_q  <= '0;
            tog_q  <= 1'b0;
            gate_q <= 1'b0;
        end else if (commit) begin
            act_q  <= stg;
            cnt_q  <= '0;
            tog_q  <= 1'b0;
            gate_q <= gate_want(stg, idle);
        end else if (!div_mode) begin
            cnt_q  <= '0;
            tog_q  <= 1'b0;
            gate_q <= 1'b0;
        end else if (term) begin
            cnt_q <= '0;
            tog_q <= ~tog_q;
            if (tog_q) begin
                gate_q <= gate_want(act_q, idle);
            end
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign act       = act_q;
    assign tog       = tog_q;
    assign gate      = gate_q;
    assign pass_mode = !div_mode;
    assign want_now  = gate_want(act_q, idle);

endmodule

// File: rtl/cclk_outgate.sv
`timescale 1ns/100ps
module cclk_outgate (
    input  logic clk,
    input  logic rst,
    input  logic pass_mode,
    input  logic want_pass,
    input  logic tog,
    input  logic gate,
    output logic cclk
);

    logic pass_n;
    logic gate_n;

    // Falling-edge registers: the source clock is low when they change.
    always_ff @(negedge clk) begin
        if (rst) begin
            pass_n <= 1'b1;
            gate_n <= 1'b0;
        end else begin
            pass_n <= pass_mode;
            gate_n <= pass_mode && want_pass;
        end
    end

    assign cclk = pass_n ? (clk && gate_n) : (tog && gate);

endmodule

// File: rtl/card_clk_div.sv
`timescale 1ns/100ps
module card_clk_div
    import cclk_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              data_busy,
    input  logic              path_idle,
    output logic              cclk_o
);

    cclk_cfg_t stg_w;
    cclk_cfg_t act_w;
    logic      pend_w;
    logic      wait_w;
    logic      commit_w;
    logic      safe_w;
    logic      tog_w;
    logic      gate_w;
    logic      pass_w;
    logic      want_w;
    logic [CCLK_DIV_W-1:0] act_ratio_w;

    cclk_stage #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_stage (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (data_busy),
        .safe     (safe_w),
        .stg      (stg_w),
        .pend     (pend_w),
        .hold_busy(wait_w),
        .commit   (commit_w),
        .rdata    (reg_rdata)
    );

    cclk_core u_core (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit_w),
        .stg      (stg_w),
        .idle     (path_idle),
        .act      (act_w),
        .tog      (tog_w),
        .gate     (gate_w),
        .safe     (safe_w),
        .pass_mode(pass_w),
        .want_now (want_w)
    );

    cclk_outgate u_out (
        .clk      (clk),
        .rst      (rst),
        .pass_mode(pass_w),
        .want_pass(want_w),
        .tog      (tog_w),
        .gate     (gate_w),
        .cclk     (cclk_o)
    );

    assign act_ratio_w = act_w.ratio;

endmodule

// File: rtl/card_clk_div_chk.sv
`timescale 1ns/100ps
module card_clk_div_chk
    import cclk_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_wr,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic                  data_busy,
    input logic                  pend,
    input logic                  waitf,
    input logic                  tog,
    input logic [CCLK_DIV_W-1:0] ratio
);

    localparam int unsigned W = CCLK_DIV_W;

    logic                tog_d;
    logic [W-1:0]        ratio_d;
    logic [W:0]          hc;
    logic                vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_d   <= 1'b0;
            ratio_d <= '0;
            hc      <= '0;
            vld     <= 1'b0;
        end else begin
            tog_d   <= tog;
            ratio_d <= ratio;
            if (ratio != ratio_d) begin
                hc  <= (W+1)'(1);
                vld <= 1'b0;
            end else if (tog != tog_d) begin
                hc  <= (W+1)'(1);
                vld <= 1'b1;
            end else if (hc != '1) begin
                hc <= hc + (W+1)'(1);
            end
        end
    end

    // R1: reset leaves no update pending and passthrough-off state
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!pend && ratio == '0));

    // R2: the active ratio moves only through a pending update
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !pend |=> $stable(ratio));

    // R3: a pending update only appears after a start+update write
    p_start_set_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(reg_wr && reg_addr == ADDR_W'(SEL_CMD)
                              && reg_wdata[CMD_START_BIT] && reg_wdata[CMD_UPD_BIT]));

    // R4 and R9: every half-period under a stable ratio lasts exactly ratio cycles
    p_half_period_r4: assert property (@(posedge clk) disable iff (rst)
        (vld && ratio != '0 && ratio == ratio_d && tog != tog_d) |-> (hc == {1'b0, ratio}));

    // R8: a waiting update never commits while the data path is busy
    p_busy_wait_r8: assert property (@(posedge clk) disable iff (rst)
        (pend && waitf && data_busy) |=> pend);

endmodule

bind card_clk_div card_clk_div_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .data_busy(data_busy),
    .pend     (pend_w),
    .waitf    (wait_w),
    .tog      (tog_w),
    .ratio    (act_ratio_w)
);

// File: tb/card_clk_div_bench.sv
`timescale 1ns/100ps
module card_clk_div_bench;

    localparam logic [31:0] CMD_UPD      = 32'h8020_0000;
    localparam logic [31:0] CMD_UPD_WAIT = 32'h8020_2000;
    localparam logic [31:0] CMD_NOUPD    = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        data_busy = 1'b0;
    logic        path_idle = 1'b0;
    logic        cclk_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    card_clk_div u_card_clk_div (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .data_busy(data_busy),
        .path_idle(path_idle),
        .cclk_o   (cclk_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ratio, m_run, m_slp, s_ratio, s_run, s_slp;
    int m_pend, m_wait, m_cnt, m_tog, m_gate, m_passn, m_gaten;
    bit m_live = 0;

    function automatic int want(int r, int s);
        return (r != 0 && !(s != 0 && path_idle)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ratio = 0; m_run = 0; m_slp = 0; s_ratio = 0; s_run = 0; s_slp = 0;
            m_pend = 0; m_wait = 0; m_cnt = 0; m_tog = 0; m_gate = 0;
        end else begin
            int divm, trm, commit;
            int n_sr, n_sn, n_sl;
            divm = (m_ratio != 0);
            trm = divm && (m_cnt == m_ratio - 1);
            commit = m_pend && !(m_wait && data_busy) && (!divm || (trm && m_tog));
            n_sr = s_ratio; n_sn = s_run; n_sl = s_slp;
            if (reg_wr && reg_addr == 2'd0) n_sr = reg_wdata[7:0];
            if (reg_wr && reg_addr == 2'd1) begin
                n_sn = reg_wdata[0]; n_sl = reg_wdata[16];
            end
            if (commit) begin
                m_ratio = s_ratio; m_run = s_run; m_slp = s_slp;
                m_cnt = 0; m_tog = 0; m_gate = want(s_run, s_slp);
                m_pend = 0; m_wait = 0;
            end else begin
                if (reg_wr && reg_addr == 2'd2 && reg_wdata[31] && reg_wdata[21] && !m_pend) begin
                    m_pend = 1; m_wait = reg_wdata[13];
                end
                if (!divm) begin
                    m_cnt = 0; m_tog = 0; m_gate = 0;
                end else if (trm) begin
                    if (m_tog) m_gate = want(m_run, m_slp);
                    m_cnt = 0; m_tog = !m_tog;
                end else begin
                    m_cnt++;
                end
            end
            s_ratio = n_sr; s_run = n_sn; s_slp = n_sl;
        end
        #1;
        if (m_live && !rst)
            chk("R9 cclk high-phase vs model", {31'd0, cclk_o},
                m_passn ? m_gaten : (m_tog & m_gate));
    end

    always @(negedge clk) begin
        if (rst) begin
            m_passn = 1; m_gaten = 0; m_live = 1;
        end else begin
            m_passn = (m_ratio == 0);
            m_gaten = m_passn ? want(m_run, m_slp) : 0;
        end
        #1;
        if (m_live && !rst)
            chk("R9 cclk low-phase vs model", {31'd0, cclk_o},
                m_passn ? 0 : (m_tog & m_gate));
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #0.5;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #0.5; d = reg_rdata;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        int n;
        n = 0;
        rd_reg(2'd2, v);
        while (v[31] && n < 700) begin
            tick(); rd_reg(2'd2, v); n++;
        end
        chk(tag, {31'd0, v[31]}, 32'd0);
    endtask

    // Measure the next high pulse length in source cycles (divided mode).
    task automatic high_len(output int len);
        logic v;
        int guard;
        guard = 0; len = 0;
        @(posedge clk); #1; v = cclk_o;
        while (v && guard < 2000) begin @(posedge clk); #1; v = cclk_o; guard++; end
        while (!v && guard < 2000) begin @(posedge clk); #1; v = cclk_o; guard++; end
        while (v && guard < 2000) begin len++; @(posedge clk); #1; v = cclk_o; guard++; end
    endtask

    task automatic low_len(output int len);
        logic v;
        int guard;
        guard = 0; len = 0;
        @(posedge clk); #1; v = cclk_o;
        while (!v && guard < 2000) begin @(posedge clk); #1; v = cclk_o; guard++; end
        while (v && guard < 2000) begin @(posedge clk); #1; v = cclk_o; guard++; end
        while (!v && guard < 2000) begin len++; @(posedge clk); #1; v = cclk_o; guard++; end
    endtask

    task automatic stays_low(input string tag, input int cycles);
        int hi;
        hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1; if (cclk_o) hi++;
            @(negedge clk); #1; if (cclk_o) hi++;
        end
        chk(tag, hi, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] v;
        int len;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        chk("R1 cclk after reset", {31'd0, cclk_o}, 32'd0);
        rd_reg(2'd2, v); chk("R1 start bit after reset", {31'd0, v[31]}, 32'd0);
        rd_reg(2'd0, v); chk("R1 staged ratio after reset", v, 32'd0);
        rd_reg(2'd1, v); chk("R1 staged gate after reset", v, 32'd0);

        // R4: half-ratio 2, enabled
        tick();
        wr_reg(2'd0, 32'd2);
        wr_reg(2'd1, 32'h0000_0001);
        wr_reg(2'd2, CMD_UPD);
        rd_reg(2'd2, v); chk("R3 start reads 1 after update write", {31'd0, v[31]}, 32'd1);
        wait_done("R3 start clears after commit");
        high_len(len); chk("R4 high length N=2", len, 2);
        low_len(len);  chk("R4 low length N=2", len, 2);

        // R2: staged write leaves the output alone
        tick();
        wr_reg(2'd0, 32'd5);
        rd_reg(2'd0, v); chk("R2 staged ratio readback", v, 32'd5);
        high_len(len); chk("R2 period unchanged before update", len, 2);

        // R3: command without update flag is ignored
        tick();
        wr_reg(2'd2, CMD_NOUPD);
        rd_reg(2'd2, v); chk("R3 start stays 0 without update flag", {31'd0, v[31]}, 32'd0);
        high_len(len); chk("R3 ignored command keeps ratio", len, 2);

        tick();
        wr_reg(2'd2, CMD_UPD);
        wait_done("R3 start clears (N=5)");
        high_len(len); chk("R4 high length N=5", len, 5);
        low_len(len);  chk("R9 low length after commit N=5", len, 5);

        // R4: largest ratio 510
        tick();
        wr_reg(2'd0, 32'd255);
        wr_reg(2'd2, CMD_UPD);
        wait_done("R3 start clears (N=255)");
        high_len(len); chk("R4 high length N=255", len, 255);
        low_len(len);  chk("R4 low length N=255", len, 255);

        // R5: passthrough
        tick();
        wr_reg(2'd0, 32'd0);
        wr_reg(2'd2, CMD_UPD);
        wait_done("R3 start clears (pass)");
        repeat (3) tick();
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1; chk("R5 pass high phase", {31'd0, cclk_o}, 32'd1);
            @(negedge clk); #1; chk("R5 pass low phase", {31'd0, cclk_o}, 32'd0);
        end

        // R6: clock disabled
        tick();
        wr_reg(2'd0, 32'd1);
        wr_reg(2'd1, 32'h0000_0000);
        wr_reg(2'd2, CMD_UPD);
        wait_done("R3 start clears (off)");
        repeat (4) tick();
        stays_low("R6 disabled clock stays low", 20);

        // R7: low-power gating
        tick();
        path_idle = 1'b1;
        wr_reg(2'd1, 32'h0001_0001);
        wr_reg(2'd2, CMD_UPD);
        wait_done("R3 start clears (lp)");
        repeat (4) tick();
        stays_low("R7 idle low-power clock low", 20);
        path_idle = 1'b0;
        high_len(len); chk("R7 clock resumes when busy path", len, 1);

        // R8: update waits for data path
        tick();
        data_busy = 1'b1;
        wr_reg(2'd0, 32'd3);
        wr_reg(2'd2, CMD_UPD_WAIT);
        repeat (40) tick();
        rd_reg(2'd2, v); chk("R8 update held while busy", {31'd0, v[31]}, 32'd1);
        high_len(len); chk("R8 old ratio while held", len, 1);
        tick();
        data_busy = 1'b0;
        wait_done("R8 update commits once not busy");
        high_len(len); chk("R8 new ratio after release", len, 3);

        tick();
        data_busy = 1'b1;
        wr_reg(2'd0, 32'd4);
        wr_reg(2'd2, CMD_UPD);
        wait_done("R8 update without wait flag commits while busy");
        high_len(len); chk("R8 ratio applied while busy", len, 4);
        data_busy = 1'b0;

        repeat (5) tick();
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule